// File: doc/BRIEF.md
# Synchronous Burst SRAM Sequencer

This block holds the control and addressing logic of a four-bank, flow-through synchronous burst static memory. The word is 72 bits wide, made of eight 9-bit lanes (eight data bits plus one parity bit each). On every rising clock edge it captures the address, the per-bank select inputs, two address strobes (a processor strobe and a controller strobe), the advance input and the write controls. From these it decides whether the cycle is idle, a read or a write, which bank it addresses, and the array address. A two-bit burst counter then walks the low two address bits, in linear or interleaved order.

The storage is a small register array per bank, with per-lane write strobes and a read enable. Reads are flow-through: the word addressed at an edge appears on `rd_data` during the cycle that follows. Writes are early: the data presented with the write controls at an edge is stored at that same edge. An asynchronous, active-low output enable gates the read data. A tri-state bus is modelled as `rd_drive` together with a `rd_data` that reads zero whenever it is not driven. Each bank has an active-high snooze input that parks it in standby.

Top module: `sbs_seq`

## Requirements
- R1: With `burst_ilv` low, each beat of a burst uses low address bits equal to (start + beat) modulo 4, where beat counts the advances since the start.
- R2: With `burst_ilv` high, each beat uses low address bits equal to start XOR beat.
- R3: During a burst only address bits [1:0] change. The upper bits stay as captured, and the order wraps after four beats.
- R4: `strobe_p_n` low with at least one `bank_en_n` bit low starts a read at the external address, even if the write controls request a write. It takes priority over `strobe_c_n`.
- R5: `strobe_c_n` low with every `bank_en_n` bit high (and no processor start) deselects. In the next cycle `rd_drive` is 0 and `rd_data` is 0.
- R6: `strobe_c_n` low with a bank enabled starts a cycle at the external address. It is a write when `gw_n` is low, or when `bwe_n` is low and some `bw_n` bit is low. Otherwise it is a read.
- R7: With no start, `adv_n` low moves to the next burst address, and `adv_n` high repeats the current address. In both cases the cycle is a write if the write controls of R6 ask for one, and a read otherwise.
- R8: `gw_n` low writes all eight lanes, whatever `bwe_n` and `bw_n` hold.
- R9: With `gw_n` high and `bwe_n` low, a low `bw_n[k]` writes lane k, which is `wr_data[9k+8:9k]` with the parity bit at `9k+8`. The other lanes keep their contents.
- R10: `rd_drive` is 1 only during a read cycle while `oe_n` is low, and it follows `oe_n` without waiting for a clock edge. It is 0 in write cycles, in idle cycles and in reset.
- R11: A cycle aimed at a bank whose `snooze` bit is high is ignored. Nothing is driven and nothing is written, and the bank keeps its contents.
- R12: When several enable bits are low, the lowest-numbered bank is selected. Read data of a cycle started at an edge appears in the cycle right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | External word address |
| bank_en_n | input | NBANK | Active-low bank selects |
| strobe_p_n | input | 1 | Processor address strobe, active low |
| strobe_c_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global (all-lane) write, active low |
| bwe_n | input | 1 | Lane-write mode enable, active low |
| bw_n | input | NBYTE | Per-lane write enables, active low |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| snooze | input | NBANK | Per-bank standby, active high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wr_data | input | NBYTE*9 | Write word, lane k at bits [9k+8:9k] |
| rd_data | output | NBYTE*9 | Read word, zero when not driven |
| rd_drive | output | 1 | Read data is being driven |

## Verification
A wrong burst counter or a wrong captured address shows up at the ports in the very next cycle, because the read is flow-through: `rd_data` then carries the contents of a neighbouring location, and every location is preloaded with a distinct pattern. A wrong cycle type (read taken as write, or a missed deselect) shows up in that same cycle on `rd_drive`. A stray write stays hidden until that location is read back, so every write-suppression case is followed by a read-back within a few cycles.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    // Width of one lane: eight data bits plus a parity bit on top.
    localparam int LANE_W = 9;
    // Burst position inside a four-word group.
    localparam int BEAT_W = 2;
endpackage

// File: rtl/sbs_burst_step.sv
// Computes the low address bits of a burst beat from the start value.
module sbs_burst_step
    import sbs_pkg::*;
(
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] beat,
    input  logic              ilv,
    output logic [BEAT_W-1:0] low
);
    always_comb begin
        if (ilv) low = start ^ beat;
        else     low = start + beat;
    end
endmodule

// File: rtl/sbs_bank_mem.sv
// One bank of storage: lane-masked synchronous write, gated combinational read.
module sbs_bank_mem
    import sbs_pkg::*;
#(
    parameter  int NBYTE  = 8,
    parameter  int ADDR_W = 4,
    localparam int DATA_W = NBYTE * LANE_W,
    localparam int DEPTH  = 2 ** ADDR_W
) (
    input  logic              clk,
    input  logic [NBYTE-1:0]  lane_we,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        for (int k = 0; k < NBYTE; k++) begin
            if (lane_we[k]) mem_q[wr_addr][k*LANE_W +: LANE_W] <= wr_data[k*LANE_W +: LANE_W];
        end
    end

    assign rd_data = rd_en ? mem_q[rd_addr] : '0;
endmodule

// File: rtl/sbs_seq.sv
module sbs_seq
    import sbs_pkg::*;
#(
    parameter  int NBANK  = 4,
    parameter  int NBYTE  = 8,
    parameter  int ADDR_W = 4,
    localparam int BANK_W = $clog2(NBANK),
    localparam int DATA_W = NBYTE * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NBANK-1:0]  bank_en_n,
    input  logic              strobe_p_n,
    input  logic              strobe_c_n,
    input  logic              adv_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [NBYTE-1:0]  bw_n,
    input  logic              burst_ilv,
    input  logic [NBANK-1:0]  snooze,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive
);
    typedef struct packed {
        logic              active;
        logic              is_wr;
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] addr;
        logic [BEAT_W-1:0] start;
        logic [BEAT_W-1:0] beat;
    } seq_t;

    seq_t st_d, st_q;

    logic              any_en;
    logic [BANK_W-1:0] en_idx;
    logic              take_p, take_c, wr_req, cont;
    logic [NBYTE-1:0]  lane_we;
    logic [BEAT_W-1:0] nxt_low;
    logic [DATA_W-1:0] bank_rd [NBANK];

    // Lowest-numbered enabled bank wins.
    always_comb begin
        any_en = 1'b0;
        en_idx = '0;
        for (int i = NBANK - 1; i >= 0; i--) begin
            if (!bank_en_n[i]) begin
                any_en = 1'b1;
                en_idx = BANK_W'(i);
            end
        end
    end

    assign wr_req  = !gw_n || (!bwe_n && !(&bw_n));
    assign lane_we = !gw_n ? {NBYTE{1'b1}} : (!bwe_n ? ~bw_n : '0);
    assign take_p  = !strobe_p_n && any_en;
    assign take_c  = !strobe_c_n && !take_p;
    assign cont    = !take_p && !take_c;

    sbs_burst_step u_step (
        .start (st_q.start),
        .beat  (st_q.beat + 2'd1),
        .ilv   (burst_ilv),
        .low   (nxt_low)
    );

    always_comb begin
        st_d = st_q;
        if (take_p || take_c) begin
            if (any_en) begin
                st_d.active = 1'b1;
                st_d.is_wr  = take_c && wr_req;
                st_d.bank   = en_idx;
                st_d.addr   = addr;
                st_d.start  = addr[BEAT_W-1:0];
                st_d.beat   = '0;
            end else begin
                st_d.active = 1'b0;
            end
        end else if (st_q.active) begin
            st_d.is_wr = wr_req;
            if (!adv_n) begin
                st_d.beat              = st_q.beat + 2'd1;
                st_d.addr[BEAT_W-1:0] = nxt_low;
            end
        end
        if (st_d.active && snooze[st_d.bank]) st_d.active = 1'b0;
        if (!st_d.active) st_d.is_wr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [NBYTE-1:0] we_b;
        logic             rd_en_b;
        assign we_b    = (st_d.active && st_d.is_wr && st_d.bank == BANK_W'(b)) ? lane_we : '0;
        assign rd_en_b = st_q.active && !st_q.is_wr && st_q.bank == BANK_W'(b);

        sbs_bank_mem #(.NBYTE(NBYTE), .ADDR_W(ADDR_W)) u_mem (
            .clk     (clk),
            .lane_we (we_b),
            .wr_addr (st_d.addr),
            .wr_data (wr_data),
            .rd_en   (rd_en_b),
            .rd_addr (st_q.addr),
            .rd_data (bank_rd[b])
        );

        p_snooze_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (|we_b) |-> !snooze[b]);
    end

    assign rd_drive = st_q.active && !st_q.is_wr && !oe_n;
    assign rd_data  = rd_drive ? bank_rd[st_q.bank] : '0;

    p_proc_start_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_p_n && any_en && !snooze[en_idx]) |=> (st_q.active && !st_q.is_wr));

    p_deselect_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_c_n && !any_en) |=> !rd_drive);

    p_suspend_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && cont && adv_n && !snooze[st_q.bank]) |=> (st_q.addr == $past(st_q.addr)));

    p_upper_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && cont && !snooze[st_q.bank])
        |=> (st_q.addr[ADDR_W-1:BEAT_W] == $past(st_q.addr[ADDR_W-1:BEAT_W])));

    p_no_drive_in_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.is_wr |-> !rd_drive);
endmodule

// File: tb/sim_sbs_seq.sv
`timescale 1ns/1ps
module sim_sbs_seq;
    localparam int DW = 72;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    addr = '0;
    logic [3:0]    bank_en_n = 4'hF;
    logic          strobe_p_n = 1'b1, strobe_c_n = 1'b1, adv_n = 1'b1;
    logic          gw_n = 1'b1, bwe_n = 1'b1;
    logic [7:0]    bw_n = 8'hFF;
    logic          burst_ilv = 1'b0;
    logic [3:0]    snooze = '0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          rd_drive;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [DW-1:0] shadow [4][16];

    always #2.5 clk = ~clk;

    sbs_seq u0 (
        .clk, .rst_n, .addr, .bank_en_n, .strobe_p_n, .strobe_c_n, .adv_n,
        .gw_n, .bwe_n, .bw_n, .burst_ilv, .snooze, .oe_n, .wr_data,
        .rd_data, .rd_drive
    );

    // {ilv, start[1:0], beat[1:0], expected low bits[1:0]}
    localparam logic [6:0] BURST_TAB [12] = '{
        7'b0_01_00_01, 7'b0_01_01_10, 7'b0_01_10_11, 7'b0_01_11_00,
        7'b0_11_01_00, 7'b0_10_10_00,
        7'b1_01_00_01, 7'b1_01_01_00, 7'b1_01_10_11, 7'b1_01_11_10,
        7'b1_10_01_11, 7'b1_11_10_01
    };

    function automatic logic [DW-1:0] pat(input int b, input int a);
        logic [DW-1:0] v;
        for (int k = 0; k < 8; k++) v[k*9 +: 9] = 9'((b * 16 + a) * 7 + k * 29 + 1);
        return v;
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in();
        strobe_p_n = 1'b1; strobe_c_n = 1'b1; adv_n = 1'b1;
        bank_en_n = 4'hF; gw_n = 1'b1; bwe_n = 1'b1; bw_n = 8'hFF;
    endtask

    task automatic start_c(input int b, input int a, input logic g, input logic be,
                           input logic [7:0] bw, input logic [DW-1:0] d);
        idle_in();
        strobe_c_n = 1'b0; bank_en_n = ~(4'b1 << b); addr = 4'(a);
        gw_n = g; bwe_n = be; bw_n = bw; wr_data = d;
        tick();
    endtask

    task automatic rd(input int b, input int a);
        start_c(b, a, 1'b1, 1'b1, 8'hFF, '0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R12 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] x1, y, m;
        // Reset state, R10
        repeat (2) @(negedge clk);
        chk("R10 reset drive", DW'(rd_drive), DW'(0));
        chk("R10 reset data", rd_data, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // Preload every word through the all-lane write path
        for (int b = 0; b < 4; b++) begin
            for (int a = 0; a < 16; a++) begin
                start_c(b, a, 1'b0, 1'b1, 8'hFF, pat(b, a));
                shadow[b][a] = pat(b, a);
            end
        end
        rd(0, 5);
        chk("R8 R12 preload read", rd_data, shadow[0][5]);

        // Burst order table, bank 2, upper address bits 01 (R1, R2, R3)
        for (int i = 0; i < 12; i++) begin
            logic [6:0] e;
            e = BURST_TAB[i];
            burst_ilv = e[6];
            start_c(2, {2'b01, e[5:4]}, 1'b1, 1'b1, 8'hFF, '0);
            idle_in();
            adv_n = 1'b0;
            for (int j = 0; j < int'(e[3:2]); j++) tick();
            idle_in();
            chk(e[6] ? "R2 R3 interleaved beat" : "R1 R3 linear beat",
                rd_data, shadow[2][{2'b01, e[1:0]}]);
        end
        burst_ilv = 1'b0;

        // R8: global write ignores lane controls
        x1 = {8{9'h1A5}};
        start_c(1, 3, 1'b0, 1'b0, 8'hFF, x1);
        shadow[1][3] = x1;
        chk("R10 no drive in write", DW'(rd_drive), DW'(0));
        rd(1, 3);
        chk("R8 full write", rd_data, shadow[1][3]);

        // R9: lane writes with parity
        y = {8{9'h15A}};
        start_c(1, 3, 1'b1, 1'b0, 8'b1010_0101, y);
        m = '0;
        for (int k = 0; k < 8; k++) if (k == 1 || k == 3 || k == 4 || k == 6) m[k*9 +: 9] = '1;
        shadow[1][3] = (y & m) | (shadow[1][3] & ~m);
        rd(1, 3);
        chk("R9 lane write", rd_data, shadow[1][3]);

        // R6: lane enables low but mode disabled -> read
        start_c(1, 3, 1'b1, 1'b1, 8'h00, '1);
        chk("R6 read drive", DW'(rd_drive), DW'(1));
        chk("R6 read data", rd_data, shadow[1][3]);

        // R4: processor strobe wins over controller strobe and write controls
        idle_in();
        strobe_p_n = 1'b0; strobe_c_n = 1'b0; bank_en_n = 4'b1110; addr = 4'd6;
        gw_n = 1'b0; wr_data = '1;
        tick();
        chk("R4 read drive", DW'(rd_drive), DW'(1));
        chk("R4 read data", rd_data, shadow[0][6]);
        rd(0, 6);
        chk("R4 nothing written", rd_data, shadow[0][6]);

        // R5: deselect
        idle_in();
        strobe_c_n = 1'b0;
        tick();
        chk("R5 deselect drive", DW'(rd_drive), DW'(0));
        chk("R5 deselect data", rd_data, '0);

        // R12: lowest enabled bank chosen
        idle_in();
        strobe_c_n = 1'b0; bank_en_n = 4'b1001; addr = 4'd9;
        tick();
        chk("R12 bank priority", rd_data, shadow[1][9]);

        // R7: suspend then advance
        rd(3, 12);
        idle_in();
        tick();
        chk("R7 suspend", rd_data, shadow[3][12]);
        adv_n = 1'b0;
        tick();
        chk("R7 advance", rd_data, shadow[3][13]);

        // R10: asynchronous output enable
        oe_n = 1'b1; #1;
        chk("R10 oe high", DW'(rd_drive), DW'(0));
        oe_n = 1'b0; #1;
        chk("R10 oe low", rd_data, shadow[3][13]);
        @(negedge clk);

        // R7: continuing write advances address
        start_c(3, 8, 1'b0, 1'b1, 8'hFF, {8{9'h0F0}});
        shadow[3][8] = {8{9'h0F0}};
        idle_in();
        gw_n = 1'b0; adv_n = 1'b0; wr_data = {8{9'h10F}};
        tick();
        shadow[3][9] = {8{9'h10F}};
        rd(3, 9);
        chk("R7 burst write next", rd_data, shadow[3][9]);
        rd(3, 8);
        chk("R7 burst write first", rd_data, shadow[3][8]);

        // R11: snoozed bank ignores cycles
        snooze = 4'b0001;
        start_c(0, 2, 1'b0, 1'b1, 8'hFF, '1);
        rd(0, 2);
        chk("R11 snooze no drive", DW'(rd_drive), DW'(0));
        snooze = '0;
        rd(0, 2);
        chk("R11 contents kept", rd_data, shadow[0][2]);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule